// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Aggregator

This block gathers the interrupt sources of an Ethernet MAC into one system status word and a single interrupt line. It accepts one-cycle event pulses from the transmit frame status logic, the wakeup filters and the station management (MDC/MDIO) shifter. It also watches the DMA grant signals of the receive and transmit channels. Software reads the latched state through a registered read port and clears it through a write port on which each 1 clears a bit.

Some sources are level conditions and some are latched. The transmit frame condition is a level: it is the OR-reduction of the transmit sticky status bits ANDed with their enable mask. The wakeup, DMA direction error and management done sources are latched bits. A DMA direction error is caught when a grant is seen while the channel is set for the wrong transfer direction. These two errors cannot be masked.

Register map (address: contents):
- 0: system status. bit0 = transmit frame summary (read-only), bit1 = wakeup detected (read-only here), bit2 = receive DMA error (write 1 to clear), bit3 = transmit DMA error (write 1 to clear), bit4 = management done (write 1 to clear).
- 1: transmit sticky status (write 1 to clear).
- 2: transmit interrupt enable (read/write).
- 3: wakeup status. bit0 = magic packet seen, bit1 = remote wakeup seen, both write 1 to clear.
- 4: management control. bit0 = management interrupt enable (read/write).

Top module: `mac_irq_agg`

## Requirements
- R1: The system status bit0 reads 1, and the interrupt is raised, exactly when some transmit sticky bit and its matching enable bit (address 2) are both 1. The enable register reads back what was written.
- R2: Writing 1s to address 1 clears those transmit sticky bits. The summary bit stays 1 while any enabled sticky bit is still set, and goes to 0 once all of them are cleared.
- R3: A magic packet event sets wakeup bit0 and a remote event sets wakeup bit1. Either event sets system bit1. Writing 1 to either wakeup status bit clears system bit1 as well as that bit.
- R4: A receive data grant or receive status grant with rx_mem_wr=0 (memory-read) sets system bit2. With rx_mem_wr=1 the grant sets nothing.
- R5: A transmit data grant with tx_mem_wr=1, or a transmit status grant with tx_mem_wr=0, sets system bit3. A data grant with tx_mem_wr=0 and a status grant with tx_mem_wr=1 set nothing.
- R6: Each DMA error bit raises the interrupt even when every enable is 0. Each clears by writing 1 to its own system status bit.
- R7: A management done pulse sets system bit4 only while the enable at address 4 bit0 is 1. The bit clears by writing 1 to it.
- R8: irq is the registered OR of bit0 through bit4 of the system status. It changes on the clock edge after the edge at which the status changes.
- R9: When a set event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R10: Writing 0 to any status bit has no effect. Writing 1 to the system summary bit0 has no effect.
- R11: A synchronous reset clears every status bit, every enable, the read data and irq.
- R12: reg_rd_data presents the register selected by reg_rd_addr on the clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write address |
| reg_wr_data | input | DATA_W | Write data (1 clears a status bit, enables are stored) |
| reg_rd_addr | input | ADDR_W | Read address |
| reg_rd_data | output | DATA_W | Registered read data |
| tx_stat_evt | input | TXS_W | Transmit frame status set pulses |
| wake_magic_evt | input | 1 | Magic packet accepted pulse |
| wake_remote_evt | input | 1 | Remote wakeup packet accepted pulse |
| mdio_done_evt | input | 1 | Management transfer complete pulse |
| rx_gnt_data | input | 1 | Receive data DMA grant |
| rx_gnt_stat | input | 1 | Receive status DMA grant |
| rx_mem_wr | input | 1 | Receive channel direction, 1 = memory-write |
| tx_gnt_data | input | 1 | Transmit data DMA grant |
| tx_gnt_stat | input | 1 | Transmit status DMA grant |
| tx_mem_wr | input | 1 | Transmit channel direction, 1 = memory-write |
| irq | output | 1 | Registered interrupt line |

## Verification
A status bit changes on the clock edge that samples its event or write. irq follows one edge later. Read data is captured on the edge after the address is applied. Every stimulus is therefore held from one falling edge to the next, and a read is sampled at the falling edge after its capture edge. An irq check waits one extra cycle before it samples. Directed tests probe the single-cycle delays of irq and of the read port at both the early and the late sample point, so a missing or extra register stage shows up as a wrong value.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  // register addresses
  localparam int unsigned REG_SYS   = 0;
  localparam int unsigned REG_TXSTK = 1;
  localparam int unsigned REG_TXIEN = 2;
  localparam int unsigned REG_WAKE  = 3;
  localparam int unsigned REG_MGMT  = 4;

  // system status bit positions
  localparam int unsigned SYS_TXF   = 0;
  localparam int unsigned SYS_WAKE  = 1;
  localparam int unsigned SYS_RXERR = 2;
  localparam int unsigned SYS_TXERR = 3;
  localparam int unsigned SYS_MGMT  = 4;
  localparam int unsigned SYS_BITS  = 5;

  // wakeup status bit positions
  localparam int unsigned WK_MAGIC  = 0;
  localparam int unsigned WK_REMOTE = 1;
  localparam int unsigned WK_BITS   = 2;

  typedef struct packed {
    logic mgmt;
    logic txerr;
    logic rxerr;
    logic wake;
    logic txf;
  } sys_stat_t;
endpackage

// File: rtl/mac_irq_sticky.sv
module mac_irq_sticky #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst) q_r <= '0;
    else     q_r <= (q_r & ~clr) | set;
  end

  assign q = q_r;

  // R9
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (|set) |=> ((q & $past(set)) == $past(set)));
  // R2
  clr_drops_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~set)) |=> ((q & $past(clr & ~set)) == '0));
  // R10
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));
endmodule

// File: rtl/mac_irq_txstat.sv
module mac_irq_txstat #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] stk_clr,
  input  logic         ien_we,
  input  logic [W-1:0] ien_wdata,
  output logic [W-1:0] stk,
  output logic [W-1:0] ien,
  output logic         cond
);
  logic [W-1:0] ien_r;

  mac_irq_sticky #(.W(W)) u_stk (
    .clk (clk),
    .rst (rst),
    .set (evt),
    .clr (stk_clr),
    .q   (stk)
  );

  always_ff @(posedge clk) begin
    if (rst)         ien_r <= '0;
    else if (ien_we) ien_r <= ien_wdata;
  end

  assign ien  = ien_r;
  assign cond = |(stk & ien_r);

  // R1
  ien_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ien_we |=> $stable(ien));
  // R2
  partial_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!ien_we && ((stk & ien & ~stk_clr) != '0)) |=> cond);
endmodule

// File: rtl/mac_irq_dmachk.sv
module mac_irq_dmachk (
  input  logic clk,
  input  logic rst,
  input  logic rx_gnt_data,
  input  logic rx_gnt_stat,
  input  logic rx_mem_wr,
  input  logic tx_gnt_data,
  input  logic tx_gnt_stat,
  input  logic tx_mem_wr,
  input  logic clr_rx,
  input  logic clr_tx,
  output logic rx_err,
  output logic tx_err
);
  localparam int unsigned NCH = 2;
  logic [NCH-1:0] bad;
  logic [NCH-1:0] err;

  // receive: both transfers must write memory
  assign bad[0] = (rx_gnt_data | rx_gnt_stat) & ~rx_mem_wr;
  // transmit: data reads memory, status writes memory
  assign bad[1] = (tx_gnt_data & tx_mem_wr) | (tx_gnt_stat & ~tx_mem_wr);

  mac_irq_sticky #(.W(NCH)) u_err (
    .clk (clk),
    .rst (rst),
    .set (bad),
    .clr ({clr_tx, clr_rx}),
    .q   (err)
  );

  assign rx_err = err[0];
  assign tx_err = err[1];

  // R4
  rx_bad_chk: assert property (@(posedge clk) disable iff (rst)
    ((rx_gnt_data || rx_gnt_stat) && !rx_mem_wr) |=> rx_err);
  // R4
  rx_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (!rx_err && rx_mem_wr) |=> !rx_err);
  // R5
  tx_bad_chk: assert property (@(posedge clk) disable iff (rst)
    ((tx_gnt_data && tx_mem_wr) || (tx_gnt_stat && !tx_mem_wr)) |=> tx_err);
  // R5
  tx_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (!tx_err && !(tx_gnt_data && tx_mem_wr) && !(tx_gnt_stat && !tx_mem_wr)) |=> !tx_err);
endmodule

// File: rtl/mac_irq_wake.sv
module mac_irq_wake
  import mac_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               magic_evt,
  input  logic               remote_evt,
  input  logic [WK_BITS-1:0] seen_clr,
  output logic [WK_BITS-1:0] seen,
  output logic               wake_det
);
  logic [WK_BITS:0] set_v;
  logic [WK_BITS:0] clr_v;
  logic [WK_BITS:0] q_v;

  always_comb begin
    set_v                 = '0;
    set_v[WK_MAGIC]       = magic_evt;
    set_v[WK_REMOTE]      = remote_evt;
    set_v[WK_BITS]        = magic_evt | remote_evt;
    clr_v                 = '0;
    clr_v[WK_BITS-1:0]    = seen_clr;
    clr_v[WK_BITS]        = |seen_clr;
  end

  mac_irq_sticky #(.W(WK_BITS + 1)) u_wk (
    .clk (clk),
    .rst (rst),
    .set (set_v),
    .clr (clr_v),
    .q   (q_v)
  );

  assign seen     = q_v[WK_BITS-1:0];
  assign wake_det = q_v[WK_BITS];

  // R3
  wake_clr_chk: assert property (@(posedge clk) disable iff (rst)
    ((|seen_clr) && !magic_evt && !remote_evt) |=> !wake_det);
  // R3
  wake_set_chk: assert property (@(posedge clk) disable iff (rst)
    (magic_evt || remote_evt) |=> wake_det);
endmodule

// File: rtl/mac_irq_agg.sv
module mac_irq_agg
  import mac_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned TXS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_wr_addr,
  input  logic [DATA_W-1:0] reg_wr_data,
  input  logic [ADDR_W-1:0] reg_rd_addr,
  output logic [DATA_W-1:0] reg_rd_data,
  input  logic [TXS_W-1:0]  tx_stat_evt,
  input  logic              wake_magic_evt,
  input  logic              wake_remote_evt,
  input  logic              mdio_done_evt,
  input  logic              rx_gnt_data,
  input  logic              rx_gnt_stat,
  input  logic              rx_mem_wr,
  input  logic              tx_gnt_data,
  input  logic              tx_gnt_stat,
  input  logic              tx_mem_wr,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_SYS   = ADDR_W'(REG_SYS);
  localparam logic [ADDR_W-1:0] A_TXSTK = ADDR_W'(REG_TXSTK);
  localparam logic [ADDR_W-1:0] A_TXIEN = ADDR_W'(REG_TXIEN);
  localparam logic [ADDR_W-1:0] A_WAKE  = ADDR_W'(REG_WAKE);
  localparam logic [ADDR_W-1:0] A_MGMT  = ADDR_W'(REG_MGMT);

  // write decode
  logic wr_sys, wr_txstk, wr_txien, wr_wake, wr_mgmt;
  assign wr_sys   = reg_wr_en && (reg_wr_addr == A_SYS);
  assign wr_txstk = reg_wr_en && (reg_wr_addr == A_TXSTK);
  assign wr_txien = reg_wr_en && (reg_wr_addr == A_TXIEN);
  assign wr_wake  = reg_wr_en && (reg_wr_addr == A_WAKE);
  assign wr_mgmt  = reg_wr_en && (reg_wr_addr == A_MGMT);

  logic [TXS_W-1:0] txstk_clr;
  logic [WK_BITS-1:0] wake_clr;
  assign txstk_clr = wr_txstk ? reg_wr_data[TXS_W-1:0] : '0;
  assign wake_clr  = wr_wake  ? reg_wr_data[WK_BITS-1:0] : '0;

  // transmit frame status
  logic [TXS_W-1:0] tx_stk, tx_ien;
  logic             tx_cond;
  mac_irq_txstat #(.W(TXS_W)) u_txstat (
    .clk       (clk),
    .rst       (rst),
    .evt       (tx_stat_evt),
    .stk_clr   (txstk_clr),
    .ien_we    (wr_txien),
    .ien_wdata (reg_wr_data[TXS_W-1:0]),
    .stk       (tx_stk),
    .ien       (tx_ien),
    .cond      (tx_cond)
  );

  // wakeup
  logic [WK_BITS-1:0] wake_seen;
  logic               wake_det;
  mac_irq_wake u_wake (
    .clk        (clk),
    .rst        (rst),
    .magic_evt  (wake_magic_evt),
    .remote_evt (wake_remote_evt),
    .seen_clr   (wake_clr),
    .seen       (wake_seen),
    .wake_det   (wake_det)
  );

  // DMA direction checks
  logic rx_err, tx_err;
  mac_irq_dmachk u_dma (
    .clk         (clk),
    .rst         (rst),
    .rx_gnt_data (rx_gnt_data),
    .rx_gnt_stat (rx_gnt_stat),
    .rx_mem_wr   (rx_mem_wr),
    .tx_gnt_data (tx_gnt_data),
    .tx_gnt_stat (tx_gnt_stat),
    .tx_mem_wr   (tx_mem_wr),
    .clr_rx      (wr_sys && reg_wr_data[SYS_RXERR]),
    .clr_tx      (wr_sys && reg_wr_data[SYS_TXERR]),
    .rx_err      (rx_err),
    .tx_err      (tx_err)
  );

  // management transfer done
  logic mgmt_ie_q;
  logic mgmt_done;
  always_ff @(posedge clk) begin
    if (rst)          mgmt_ie_q <= 1'b0;
    else if (wr_mgmt) mgmt_ie_q <= reg_wr_data[0];
  end

  mac_irq_sticky #(.W(1)) u_mgmt (
    .clk (clk),
    .rst (rst),
    .set (mdio_done_evt & mgmt_ie_q),
    .clr (wr_sys & reg_wr_data[SYS_MGMT]),
    .q   (mgmt_done)
  );

  // system status and interrupt
  sys_stat_t sys;
  always_comb begin
    sys.txf   = tx_cond;
    sys.wake  = wake_det;
    sys.rxerr = rx_err;
    sys.txerr = tx_err;
    sys.mgmt  = mgmt_done;
  end

  logic irq_q;
  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |sys;
  end
  assign irq = irq_q;

  // registered read port
  logic [DATA_W-1:0] rd_nxt, rd_q;
  always_comb begin
    rd_nxt = '0;
    case (reg_rd_addr)
      A_SYS:   rd_nxt[SYS_BITS-1:0] = sys;
      A_TXSTK: rd_nxt[TXS_W-1:0]    = tx_stk;
      A_TXIEN: rd_nxt[TXS_W-1:0]    = tx_ien;
      A_WAKE:  rd_nxt[WK_BITS-1:0]  = wake_seen;
      A_MGMT:  rd_nxt[0]            = mgmt_ie_q;
      default: rd_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= rd_nxt;
  end
  assign reg_rd_data = rd_q;

  // R8
  irq_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(rx_err || tx_err || tx_cond || wake_det || mgmt_done));
  // R8
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_cond || wake_det || mgmt_done) |=> irq);
  // R6
  dma_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    (rx_err || tx_err) |=> irq);
  // R7
  mgmt_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!mgmt_ie_q && !mgmt_done) |=> !mgmt_done);
endmodule

// File: tb/mac_irq_agg_bench.sv
module mac_irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 16;
  localparam int TXS_W  = 8;
  localparam int VW     = 49;
  localparam int NV     = 59;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2, K_IRQ = 2'd3;

  // vector: {req[3:0], kind[1:0], addr[2:0], data[23:0], exp[15:0]}
  // event data bits: [7:0] tx_stat_evt, 8 magic, 9 remote, 10 mdio_done,
  // 11 rx_gnt_data, 12 rx_gnt_stat, 13 rx_mem_wr, 14 tx_gnt_data, 15 tx_gnt_stat, 16 tx_mem_wr
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd11, K_RD,  3'd0, 24'h0,     16'h00},  // R11 reset state
    {4'd1,  K_WR,  3'd2, 24'h5,     16'h00},  // R1
    {4'd1,  K_RD,  3'd2, 24'h0,     16'h05},
    {4'd1,  K_EV,  3'd0, 24'h0F,    16'h00},
    {4'd1,  K_RD,  3'd1, 24'h0,     16'h0F},
    {4'd1,  K_RD,  3'd0, 24'h0,     16'h01},
    {4'd1,  K_IRQ, 3'd0, 24'h0,     16'h01},
    {4'd2,  K_WR,  3'd1, 24'h01,    16'h00},  // R2 partial clear
    {4'd2,  K_RD,  3'd0, 24'h0,     16'h01},
    {4'd2,  K_IRQ, 3'd0, 24'h0,     16'h01},
    {4'd2,  K_WR,  3'd1, 24'h04,    16'h00},
    {4'd2,  K_RD,  3'd1, 24'h0,     16'h0A},
    {4'd2,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd2,  K_IRQ, 3'd0, 24'h0,     16'h00},
    {4'd2,  K_WR,  3'd1, 24'h0A,    16'h00},
    {4'd2,  K_RD,  3'd1, 24'h0,     16'h00},
    {4'd3,  K_EV,  3'd0, 24'h100,   16'h00},  // R3
    {4'd3,  K_RD,  3'd3, 24'h0,     16'h01},
    {4'd3,  K_RD,  3'd0, 24'h0,     16'h02},
    {4'd3,  K_IRQ, 3'd0, 24'h0,     16'h01},
    {4'd3,  K_EV,  3'd0, 24'h200,   16'h00},
    {4'd3,  K_RD,  3'd3, 24'h0,     16'h03},
    {4'd3,  K_WR,  3'd3, 24'h01,    16'h00},
    {4'd3,  K_RD,  3'd3, 24'h0,     16'h02},
    {4'd3,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd3,  K_IRQ, 3'd0, 24'h0,     16'h00},
    {4'd3,  K_WR,  3'd3, 24'h02,    16'h00},
    {4'd3,  K_RD,  3'd3, 24'h0,     16'h00},
    {4'd4,  K_EV,  3'd0, 24'h2800,  16'h00},  // R4 good directions
    {4'd4,  K_EV,  3'd0, 24'h3000,  16'h00},
    {4'd4,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd4,  K_EV,  3'd0, 24'h800,   16'h00},
    {4'd4,  K_RD,  3'd0, 24'h0,     16'h04},
    {4'd6,  K_IRQ, 3'd0, 24'h0,     16'h01},  // R6
    {4'd6,  K_WR,  3'd0, 24'h04,    16'h00},
    {4'd6,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd4,  K_EV,  3'd0, 24'h1000,  16'h00},
    {4'd4,  K_RD,  3'd0, 24'h0,     16'h04},
    {4'd6,  K_WR,  3'd0, 24'h04,    16'h00},
    {4'd5,  K_EV,  3'd0, 24'h4000,  16'h00},  // R5 good directions
    {4'd5,  K_EV,  3'd0, 24'h18000, 16'h00},
    {4'd5,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd5,  K_EV,  3'd0, 24'h14000, 16'h00},
    {4'd5,  K_RD,  3'd0, 24'h0,     16'h08},
    {4'd5,  K_WR,  3'd0, 24'h08,    16'h00},
    {4'd5,  K_EV,  3'd0, 24'h8000,  16'h00},
    {4'd5,  K_RD,  3'd0, 24'h0,     16'h08},
    {4'd5,  K_WR,  3'd0, 24'h08,    16'h00},
    {4'd5,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd7,  K_EV,  3'd0, 24'h400,   16'h00},  // R7 gated off
    {4'd7,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd7,  K_WR,  3'd4, 24'h1,     16'h00},
    {4'd7,  K_RD,  3'd4, 24'h0,     16'h01},
    {4'd7,  K_EV,  3'd0, 24'h400,   16'h00},
    {4'd7,  K_RD,  3'd0, 24'h0,     16'h10},
    {4'd8,  K_IRQ, 3'd0, 24'h0,     16'h01},  // R8
    {4'd7,  K_WR,  3'd0, 24'h10,    16'h00},
    {4'd7,  K_RD,  3'd0, 24'h0,     16'h00},
    {4'd8,  K_IRQ, 3'd0, 24'h0,     16'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr_en = 1'b0;
  logic [ADDR_W-1:0] reg_wr_addr = '0;
  logic [DATA_W-1:0] reg_wr_data = '0;
  logic [ADDR_W-1:0] reg_rd_addr = '0;
  logic [DATA_W-1:0] reg_rd_data;
  logic [TXS_W-1:0] tx_stat_evt = '0;
  logic wake_magic_evt = 1'b0, wake_remote_evt = 1'b0, mdio_done_evt = 1'b0;
  logic rx_gnt_data = 1'b0, rx_gnt_stat = 1'b0, rx_mem_wr = 1'b0;
  logic tx_gnt_data = 1'b0, tx_gnt_stat = 1'b0, tx_mem_wr = 1'b0;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_irq_agg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TXS_W(TXS_W)) u_mac_irq_agg (
    .clk (clk), .rst (rst),
    .reg_wr_en (reg_wr_en), .reg_wr_addr (reg_wr_addr), .reg_wr_data (reg_wr_data),
    .reg_rd_addr (reg_rd_addr), .reg_rd_data (reg_rd_data),
    .tx_stat_evt (tx_stat_evt), .wake_magic_evt (wake_magic_evt),
    .wake_remote_evt (wake_remote_evt), .mdio_done_evt (mdio_done_evt),
    .rx_gnt_data (rx_gnt_data), .rx_gnt_stat (rx_gnt_stat), .rx_mem_wr (rx_mem_wr),
    .tx_gnt_data (tx_gnt_data), .tx_gnt_stat (tx_gnt_stat), .tx_mem_wr (tx_mem_wr),
    .irq (irq)
  );

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_events(input logic [23:0] d);
    tx_stat_evt     = d[7:0];
    wake_magic_evt  = d[8];
    wake_remote_evt = d[9];
    mdio_done_evt   = d[10];
    rx_gnt_data     = d[11];
    rx_gnt_stat     = d[12];
    rx_mem_wr       = d[13];
    tx_gnt_data     = d[14];
    tx_gnt_stat     = d[15];
    tx_mem_wr       = d[16];
  endtask

  task automatic do_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wr_data = '0;
  endtask

  task automatic do_ev(input logic [23:0] d);
    set_events(d);
    @(negedge clk);
    set_events('0);
  endtask

  task automatic do_rd(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e);
    reg_rd_addr = a;
    @(negedge clk);
    chk(req, reg_rd_data, e);
  endtask

  task automatic do_irq(input string req, input logic e);
    @(negedge clk);
    chk(req, {15'd0, irq}, {15'd0, e});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R11 reset values of irq
    chk("R11", {15'd0, irq}, 16'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] kd;
      logic [2:0] ad;
      logic [23:0] dt;
      logic [15:0] ex;
      string rs;
      {rq, kd, ad, dt, ex} = VEC[i];
      rs = $sformatf("R%0d vec%0d", rq, i);
      case (kd)
        K_WR:  do_wr(ad, dt[DATA_W-1:0]);
        K_RD:  do_rd(rs, ad, ex);
        K_EV:  do_ev(dt);
        default: do_irq(rs, ex[0]);
      endcase
    end

    // R6: DMA error raises irq with all enables off
    do_wr(3'd2, 16'h0);
    do_wr(3'd4, 16'h0);
    do_irq("R6 idle", 1'b0);
    do_ev(24'h4000 | 24'h10000);
    do_irq("R6 unmasked", 1'b1);
    do_wr(3'd0, 16'h08);
    do_rd("R6 clear", 3'd0, 16'h00);

    // R8: irq lags status by exactly one edge
    do_irq("R8 before", 1'b0);
    set_events(24'h800);
    @(negedge clk);
    set_events('0);
    chk("R8 early", {15'd0, irq}, 16'h0);
    @(negedge clk);
    chk("R8 late", {15'd0, irq}, 16'h1);

    // R10: zero writes and summary writes do nothing
    do_wr(3'd0, 16'h00);
    do_rd("R10 zero write", 3'd0, 16'h04);
    do_wr(3'd0, 16'h04);
    do_wr(3'd2, 16'h01);
    do_ev(24'h01);
    do_wr(3'd0, 16'h01);
    do_rd("R10 summary ro", 3'd0, 16'h01);
    do_wr(3'd1, 16'h00);
    do_rd("R10 stk zero", 3'd1, 16'h01);
    do_wr(3'd1, 16'h01);

    // R9: set beats clear in the same cycle
    set_events(24'h800);
    reg_wr_en = 1'b1; reg_wr_addr = 3'd0; reg_wr_data = 16'h04;
    @(negedge clk);
    set_events('0); reg_wr_en = 1'b0; reg_wr_data = '0;
    do_rd("R9 dma", 3'd0, 16'h04);
    do_wr(3'd0, 16'h04);
    set_events(24'h02);
    reg_wr_en = 1'b1; reg_wr_addr = 3'd1; reg_wr_data = 16'h02;
    @(negedge clk);
    set_events('0); reg_wr_en = 1'b0; reg_wr_data = '0;
    do_rd("R9 txstk", 3'd1, 16'h02);
    set_events(24'h100);
    reg_wr_en = 1'b1; reg_wr_addr = 3'd3; reg_wr_data = 16'h01;
    @(negedge clk);
    set_events('0); reg_wr_en = 1'b0; reg_wr_data = '0;
    do_rd("R9 wake", 3'd0, 16'h02);

    // R12: read data moves one edge after the address
    do_wr(3'd2, 16'h33);
    do_rd("R12 setup", 3'd2, 16'h33);
    reg_rd_addr = 3'd3;
    #1;
    chk("R12 early", reg_rd_data, 16'h33);
    @(negedge clk);
    chk("R12 late", reg_rd_data, 16'h01);

    // R11: reset mid-run clears everything
    do_ev(24'h800 | 24'hFF);
    do_wr(3'd4, 16'h1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 irq", {15'd0, irq}, 16'h0);
    chk("R11 rdata", reg_rd_data, 16'h0);
    do_rd("R11 sys", 3'd0, 16'h00);
    do_rd("R11 stk", 3'd1, 16'h00);
    do_rd("R11 ien", 3'd2, 16'h00);
    do_rd("R11 wake", 3'd3, 16'h00);
    do_rd("R11 mgmt", 3'd4, 16'h00);

    finish_run();
  end
endmodule